// File: doc/BRIEF.md
# Decimating Averaging Sample Accumulator

This block sits behind the ADC capture path and ahead of the memory writer. It takes four lanes of 14-bit signed samples, one set per clock, and lowers the rate by a programmable factor. Only lanes 0 and 1 matter in dual-lane mode. In each group of samples it either keeps the first sample of the group (decimation) or the sum of all samples in the group (averaging). It then shifts the result right arithmetically by a programmable amount and packs it into 64-bit words with a valid strobe.

The trigger logic drives a sample window signal. Samples count only while the window is high. Group counting always starts over at the first sample after the window opens, so every record lines up with its trigger. A group that is only partly gathered when the window closes is dropped.

Two state machines do the work:
- **Group machine**
  - `GRP_FIRST` waits for the first sample of a group.
  - `GRP_REST` gathers the remaining samples.
  - Transitions: first-sample-taken (to `GRP_REST`), group-complete (to `GRP_FIRST`) and window-closed (to `GRP_FIRST`). With a factor of one, `GRP_FIRST` completes a group on every sample.
- **Output machine**
  - `OUT_NONE` is idle.
  - `OUT_LO` presents the lane 0/1 word.
  - `OUT_HI` presents the lane 2/3 word.
  - Transitions: result-ready (to `OUT_LO`), quad-follow-on (to `OUT_HI`) and drained (to `OUT_NONE`).

Top module: `dec_avg_acc`

## Requirements
- R1: While reset is held and in the first cycle after its release, `out_valid` is 0 and `out_word` is all zero.
- R2: With `cfg_avg`=0, each group of `cfg_factor`+1 windowed samples yields the group's first sample. The word appears with `out_valid` high in the cycle after the clock edge that takes the group's last sample, and at no other time.
- R3: With `cfg_avg`=1, each result is the signed sum of all `cfg_factor`+1 samples of its group.
- R4: Before packing, each result is shifted right arithmetically (sign-preserving) by `cfg_shift` bit positions, from 0 to 15.
- R5: Each word carries two lanes. The lower lane is in bits 23:0 and the higher lane in bits 55:32, each the low 24 bits of its shifted result. Bits 31:24 and 63:56 are zero.
- R6: With `cfg_quad`=1, each result produces two words on consecutive cycles. The first holds lanes 0 and 1, the second holds lanes 2 and 3. `cfg_factor` must then be at least 1.
- R7: When `sample_win` falls, a partly gathered group is discarded and produces no word. Counting restarts with the first sample after `sample_win` rises again.
- R8: With `cfg_factor`=0 in dual-lane mode, every windowed sample produces one word, on back-to-back cycles.
- R9: The sum is held at full precision with no wrap for any factor up to 2^18. With a factor of 65536, a shift of 15 and full-scale lanes (-8192 and +8191), the outputs are -16384 and +16382.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_win | input | 1 | Window from the trigger logic; samples are taken while high |
| smp_in | input | 56 | Four 14-bit signed samples; lane n in bits 14n+13:14n |
| cfg_factor | input | 18 | Decimation factor minus one |
| cfg_avg | input | 1 | 1 sums each group, 0 keeps the first sample |
| cfg_shift | input | 4 | Arithmetic right shift applied to each result |
| cfg_quad | input | 1 | 1 emits a second word with lanes 2 and 3 |
| out_valid | output | 1 | Strobe marking a valid output word |
| out_word | output | 64 | Packed output word |

## Verification
A group counter that drifts shows up at once, in the next group: the valid strobe lands a cycle early or late. The word also holds a shifted first sample or a sum over the wrong samples. An accumulator that fails to restart carries the previous group's sum into the next word. A stale partial group left after the window closes corrupts the first word of the next record. An output machine stuck in the wrong state drops or repeats the lane 2/3 word within two cycles. The bench therefore pins every word to the exact cycle it is due, as well as to its value.

// File: rtl/dec_pkg.sv
package dec_pkg;

    typedef enum logic [0:0] {
        GRP_FIRST,
        GRP_REST
    } grp_state_t;

    typedef enum logic [1:0] {
        OUT_NONE,
        OUT_LO,
        OUT_HI
    } out_state_t;

endpackage

// File: rtl/dec_group_ctrl.sv
module dec_group_ctrl
    import dec_pkg::*;
#(
    parameter int FACT_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_win,
    input  logic [FACT_W-1:0] cfg_factor,
    output logic              take_first,
    output logic              take_more,
    output logic              grp_done
);

    grp_state_t        state, nxt_state;
    logic [FACT_W-1:0] cnt, nxt_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= GRP_FIRST;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    // transitions and strobes
    always_comb begin
        nxt_state  = state;
        nxt_cnt    = cnt;
        take_first = 1'b0;
        take_more  = 1'b0;
        grp_done   = 1'b0;
        unique case (state)
            GRP_FIRST: begin
                if (sample_win) begin
                    take_first = 1'b1;
                    if (cfg_factor == '0) begin
                        grp_done = 1'b1;
                    end else begin
                        nxt_state = GRP_REST;
                        nxt_cnt   = FACT_W'(1);
                    end
                end
            end
            GRP_REST: begin
                if (!sample_win) begin
                    nxt_state = GRP_FIRST;
                    nxt_cnt   = '0;
                end else begin
                    take_more = 1'b1;
                    if (cnt >= cfg_factor) begin
                        grp_done  = 1'b1;
                        nxt_state = GRP_FIRST;
                        nxt_cnt   = '0;
                    end else begin
                        nxt_cnt = cnt + FACT_W'(1);
                    end
                end
            end
            default: begin
                nxt_state = GRP_FIRST;
                nxt_cnt   = '0;
            end
        endcase
    end

endmodule

// File: rtl/dec_chan_acc.sv
module dec_chan_acc #(
    parameter int SMP_W  = 14,
    parameter int ACC_W  = 32,
    parameter int SH_W   = 4,
    parameter int HALF_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SMP_W-1:0]  smp,
    input  logic              take_first,
    input  logic              take_more,
    input  logic              cfg_avg,
    input  logic [SH_W-1:0]   cfg_shift,
    output logic [HALF_W-1:0] res
);

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] sext;
    logic signed [ACC_W-1:0] total;
    logic signed [ACC_W-1:0] shifted;

    assign sext = {{(ACC_W-SMP_W){smp[SMP_W-1]}}, smp};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (take_first) begin
            acc <= sext;
        end else if (take_more && cfg_avg) begin
            acc <= acc + sext;
        end
    end

    // value of the group including the sample taken this cycle
    always_comb begin
        if (take_first) begin
            total = sext;
        end else if (cfg_avg) begin
            total = acc + sext;
        end else begin
            total = acc;
        end
        shifted = total >>> cfg_shift;
    end

    assign res = shifted[HALF_W-1:0];

endmodule

// File: rtl/dec_out_seq.sv
module dec_out_seq
    import dec_pkg::*;
#(
    parameter int HALF_W = 24,
    parameter int WORD_W = 64,
    parameter int NCH    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  grp_done,
    input  logic                  cfg_quad,
    input  logic [NCH*HALF_W-1:0] res_all,
    output logic                  out_valid,
    output logic [WORD_W-1:0]     out_word
);

    localparam int LANE_W = WORD_W / 2;
    localparam int PAD_W  = LANE_W - HALF_W;

    out_state_t        state, nxt_state;
    logic [WORD_W-1:0] lo_q, hi_q;
    logic [WORD_W-1:0] lo_d, hi_d;

    always_comb begin
        lo_d = {{PAD_W{1'b0}}, res_all[1*HALF_W +: HALF_W],
                {PAD_W{1'b0}}, res_all[0*HALF_W +: HALF_W]};
        hi_d = {{PAD_W{1'b0}}, res_all[3*HALF_W +: HALF_W],
                {PAD_W{1'b0}}, res_all[2*HALF_W +: HALF_W]};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= OUT_NONE;
        end else begin
            state <= nxt_state;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (grp_done) begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    always_comb begin
        nxt_state = OUT_NONE;
        unique case (state)
            OUT_NONE: nxt_state = OUT_NONE;
            OUT_LO:   nxt_state = cfg_quad ? OUT_HI : OUT_NONE;
            OUT_HI:   nxt_state = OUT_NONE;
            default:  nxt_state = OUT_NONE;
        endcase
        if (grp_done) begin
            nxt_state = OUT_LO;
        end
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        out_word  = lo_q;
        unique case (state)
            OUT_NONE: out_valid = 1'b0;
            OUT_LO:   out_valid = 1'b1;
            OUT_HI: begin
                out_valid = 1'b1;
                out_word  = hi_q;
            end
            default:  out_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/dec_avg_acc.sv
module dec_avg_acc #(
    parameter int SMP_W  = 14,
    parameter int FACT_W = 18,
    parameter int SH_W   = 4,
    parameter int HALF_W = 24,
    parameter int WORD_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_win,
    input  logic [4*SMP_W-1:0]   smp_in,
    input  logic [FACT_W-1:0]    cfg_factor,
    input  logic                 cfg_avg,
    input  logic [SH_W-1:0]      cfg_shift,
    input  logic                 cfg_quad,
    output logic                 out_valid,
    output logic [WORD_W-1:0]    out_word
);

    localparam int NCH   = 4;
    localparam int ACC_W = SMP_W + FACT_W;

    logic                  take_first;
    logic                  take_more;
    logic                  grp_done;
    logic [NCH*HALF_W-1:0] res_all;

    dec_group_ctrl #(.FACT_W(FACT_W)) u_grp (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_win (sample_win),
        .cfg_factor (cfg_factor),
        .take_first (take_first),
        .take_more  (take_more),
        .grp_done   (grp_done)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
        dec_chan_acc #(
            .SMP_W  (SMP_W),
            .ACC_W  (ACC_W),
            .SH_W   (SH_W),
            .HALF_W (HALF_W)
        ) u_acc (
            .clk        (clk),
            .rst_n      (rst_n),
            .smp        (smp_in[ch*SMP_W +: SMP_W]),
            .take_first (take_first),
            .take_more  (take_more),
            .cfg_avg    (cfg_avg),
            .cfg_shift  (cfg_shift),
            .res        (res_all[ch*HALF_W +: HALF_W])
        );
    end

    dec_out_seq #(
        .HALF_W (HALF_W),
        .WORD_W (WORD_W),
        .NCH    (NCH)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .grp_done  (grp_done),
        .cfg_quad  (cfg_quad),
        .res_all   (res_all),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

endmodule

// File: rtl/dec_avg_acc_chk.sv
module dec_avg_acc_chk #(
    parameter int FACT_W = 18,
    parameter int HALF_W = 24,
    parameter int WORD_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_win,
    input logic              grp_done,
    input logic              cfg_quad,
    input logic [FACT_W-1:0] cfg_factor,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_word
);

    localparam int LANE_W = WORD_W / 2;

    // R2: a finished group shows up on the next cycle
    a_r2_word_follows_group: assert property (@(posedge clk) disable iff (!rst_n)
        grp_done |=> out_valid);

    // R2: no strobe without a finished group one or two cycles back
    a_r2_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(grp_done) || ($past(grp_done, 2) && $past(cfg_quad, 2))));

    // R6: quad mode yields a second word right after the first
    a_r6_second_word: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_done && cfg_quad) |=> ##1 out_valid);

    // R5: gap bits above each lane stay zero
    a_r5_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_word[LANE_W-1:HALF_W] == '0 && out_word[WORD_W-1:LANE_W+HALF_W] == '0));

    // R7: the first sample after the window opens cannot close a multi-sample group
    a_r7_restart_on_open: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_win && !$past(sample_win) && cfg_factor != '0) |-> !grp_done);

endmodule

bind dec_avg_acc dec_avg_acc_chk #(
    .FACT_W (FACT_W),
    .HALF_W (HALF_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_win (sample_win),
    .grp_done   (grp_done),
    .cfg_quad   (cfg_quad),
    .cfg_factor (cfg_factor),
    .out_valid  (out_valid),
    .out_word   (out_word)
);

// File: tb/test_dec_avg_acc.sv
module test_dec_avg_acc;

    localparam int SMP_W = 14;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sample_win;
    logic [55:0] smp_in;
    logic [17:0] cfg_factor;
    logic        cfg_avg;
    logic [3:0]  cfg_shift;
    logic        cfg_quad;
    logic        out_valid;
    logic [63:0] out_word;

    always #10 clk = ~clk;

    dec_avg_acc i_dec_avg_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_win (sample_win),
        .smp_in     (smp_in),
        .cfg_factor (cfg_factor),
        .cfg_avg    (cfg_avg),
        .cfg_shift  (cfg_shift),
        .cfg_quad   (cfg_quad),
        .out_valid  (out_valid),
        .out_word   (out_word)
    );

    int     n_chk = 0;
    int     n_fail = 0;
    longint cyc = 0;
    bit     mon_on = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [63:0] w;
        longint      due;
        string       tag;
    } exp_t;

    exp_t   q[$];
    int     mcnt;
    longint msum[4];
    longint mfirst[4];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    function automatic logic [63:0] pack(input longint a, input longint b);
        logic [63:0] w;
        w = '0;
        w[23:0]  = a[23:0];
        w[55:32] = b[23:0];
        return w;
    endfunction

    function automatic logic [55:0] pat(input int k, input int seed);
        logic [55:0] s;
        for (int ch = 0; ch < 4; ch++) begin
            int v;
            v = ((k * (2 * ch + 37) + seed * 101 + ch * 3001) % 16384) - 8192;
            if (k % 11 == 5) v = -8192;
            if (k % 13 == 7) v = 8191;
            s[ch*SMP_W +: SMP_W] = v[13:0];
        end
        return s;
    endfunction

    // drive one cycle and advance the reference model
    task automatic step(input logic en, input logic [55:0] s, input string tag);
        @(negedge clk);
        sample_win = en;
        smp_in     = s;
        if (en) begin
            for (int ch = 0; ch < 4; ch++) begin
                logic signed [13:0] t;
                t = s[ch*SMP_W +: SMP_W];
                if (mcnt == 0) begin
                    mfirst[ch] = t;
                    msum[ch]   = t;
                end else begin
                    msum[ch] += t;
                end
            end
            mcnt++;
            if (mcnt == int'(cfg_factor) + 1) begin
                longint r[4];
                exp_t e;
                for (int ch = 0; ch < 4; ch++) begin
                    r[ch] = (cfg_avg ? msum[ch] : mfirst[ch]) >>> cfg_shift;
                end
                e.w = pack(r[0], r[1]); e.due = cyc + 1; e.tag = tag;
                q.push_back(e);
                if (cfg_quad) begin
                    e.w = pack(r[2], r[3]); e.due = cyc + 2; e.tag = tag;
                    q.push_back(e);
                end
                mcnt = 0;
            end
        end else begin
            mcnt = 0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, "R2");
    endtask

    task automatic set_cfg(input int f, input bit avg, input int sh, input bit quad);
        idle(3);
        cfg_factor = 18'(f);
        cfg_avg    = avg;
        cfg_shift  = 4'(sh);
        cfg_quad   = quad;
        mcnt       = 0;
    endtask

    // output monitor: every word checked for value and arrival cycle
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2", "unexpected valid", out_word, '0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(out_word == e.w, e.tag, "word value", out_word, e.w);
                    check(e.due == cyc, e.tag, "word timing", 64'(cyc), 64'(e.due));
                end
            end else if (q.size() > 0 && q[0].due <= cyc) begin
                exp_t e;
                e = q.pop_front();
                check(1'b0, e.tag, "missing word", out_word, e.w);
            end
        end
    end

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; sample_win = 1'b0; smp_in = '0;
        cfg_factor = '0; cfg_avg = 1'b0; cfg_shift = '0; cfg_quad = 1'b0;
        mcnt = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "valid in reset", 64'(out_valid), 0);
        check(out_word == '0, "R1", "word in reset", out_word, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid after release", 64'(out_valid), 0);
        mon_on = 1'b1;

        // R2 R3 R4 R8: dual-lane sweep of mode, factor and shift
        for (int avg = 0; avg < 2; avg++) begin
            for (int f = 0; f < 6; f++) begin
                for (int sh = 0; sh < 4; sh++) begin
                    string tag;
                    tag = (avg != 0) ? "R3" : "R2";
                    if (sh != 0) tag = "R4";
                    if (f == 0) tag = "R8";
                    set_cfg(f, avg[0], sh * 5, 1'b0);
                    for (int k = 0; k < 3 * (f + 1); k++) step(1'b1, pat(k, f * 7 + sh + avg), tag);
                end
            end
        end

        // R6: four-lane mode
        for (int avg = 0; avg < 2; avg++) begin
            for (int f = 1; f < 5; f++) begin
                set_cfg(f, avg[0], f, 1'b1);
                for (int k = 0; k < 4 * (f + 1); k++) step(1'b1, pat(k, 50 + f + avg), "R6");
            end
        end

        // R7: partial group dropped, counting restarts on reopen
        set_cfg(3, 1'b1, 0, 1'b0);
        step(1'b1, pat(1, 90), "R7");
        step(1'b1, pat(2, 90), "R7");
        step(1'b0, '0, "R7");
        for (int k = 0; k < 8; k++) step(1'b1, pat(k + 3, 91), "R7");
        // R7: irregular window with four-lane output
        set_cfg(2, 1'b1, 1, 1'b1);
        for (int k = 0; k < 60; k++) step((k % 7) != 3 && (k % 9) != 5, pat(k, 92), "R7");

        // R5: full-scale packing and sign extension
        set_cfg(0, 1'b0, 0, 1'b0);
        step(1'b1, {14'sd0, 14'sd0, 14'sd8191, -14'sd8192}, "R5");
        step(1'b1, {14'sd0, 14'sd0, -14'sd8192, 14'sd8191}, "R5");
        step(1'b1, {14'sd0, 14'sd0, -14'sd1, 14'sd1}, "R5");

        // R9: long sum of full-scale samples, no wrap
        set_cfg(65535, 1'b1, 15, 1'b0);
        for (int k = 0; k < 65536; k++) step(1'b1, {14'sd0, 14'sd0, 14'sd8191, -14'sd8192}, "R9");
        idle(4);
        check(pack(-16384, 16382) == 64'h0000_3FFE_00FF_C000, "R9", "reference value",
              pack(-16384, 16382), 64'h0000_3FFE_00FF_C000);

        idle(5);
        check(q.size() == 0, "R2", "words left undelivered", 64'(q.size()), 0);
        summary();
        $finish;
    end

endmodule